// File: doc/BRIEF.md
# Fully Associative Line Directory with Age-Based Replacement

This block is the lookup and replacement engine of a small fully associative cache. It keeps 64 directory entries. Each entry holds a valid flag and a 14-bit line tag. A 20-bit byte address with 64-byte lines leaves exactly 14 bits of tag. Any memory line may sit in any entry. A lookup compares the request tag against every entry at once and, on a match, reports a hit and the index of the entry that holds the tag.

Every entry has a saturating age counter. The counter advances on every clock and is cleared whenever its entry is accessed. A priority stage picks the victim for the next allocation. Empty entries come first. Among full entries, the one with the largest age wins. When the caller raises the allocate strobe, the tag on the lookup port is installed at the victim entry. Line data, the memory side and write handling belong to the surrounding cache.

Top module: `assoc_tag_dir`

## Requirements
- R1: After reset every entry is empty. A lookup of any tag gives `hit` = 0, and `victimIndex` is 0.
- R2: In the same cycle, `hit` is 1 exactly when `lookupValid` is 1 and a valid entry holds `lookupTag`. `hitIndex` then gives that entry's index, and it is 0 when `hit` is 0.
- R3: An allocate (`allocValid` = 1) whose tag is in no valid entry writes the tag into entry `victimIndex` at the clock edge and marks that entry valid. From the next cycle a lookup of that tag hits at that index, and the tag that was held there before misses.
- R4: While any entry is empty, `victimIndex` is the lowest-numbered empty entry.
- R5: Each entry's age counter is 8 bits wide. It increases by one on every clock unless cleared, and it stops at 255 without wrapping to 0.
- R6: A lookup hit clears the age of the matching entry at the clock edge. An allocate clears the age of the entry it fills.
- R7: When all entries are valid, `victimIndex` is the entry with the largest age. On a tie, the lowest index wins.
- R8: An allocate whose tag is already held by a valid entry changes nothing. No second copy is made, and the victim entry keeps its tag and age.
- R9: With `lookupValid` = 0, `hit` is 0 and no age is cleared by the lookup port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup strobe |
| allocValid | input | 1 | Allocate strobe; installs `lookupTag` at the victim |
| lookupTag | input | 14 | Line tag for lookup and allocate |
| hit | output | 1 | Lookup matched a valid entry |
| hitIndex | output | 6 | Index of the matching entry |
| victimIndex | output | 6 | Entry the next allocate will fill |

## Verification
The assertions assume that the caller never allocates a tag in a way that leaves two valid entries holding the same tag. The directory itself enforces this by dropping an allocate of a tag that is already present, and the one-match property relies on that rule. The directed stimulus fills the directory with distinct tags and tries to allocate a duplicate only on purpose, to check that it is dropped. The property that ages never wrap assumes that the counters start from reset. The bench runs idle stretches of more than 256 cycles to drive every counter into saturation.

// File: rtl/assoc_dir_pkg.sv
package assoc_dir_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clearHit;   // clear age of matching entry
    logic install;    // write tag into victim entry
  } dirStrobe_t;
endpackage

// File: rtl/assoc_dir_victim.sv
module assoc_dir_victim #(
  parameter int ENTRIES = 64,
  parameter int AGE_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ENTRIES-1:0]              validVec,
  input  logic [ENTRIES-1:0][AGE_W-1:0]   ageVec,
  output logic [IDX_W-1:0]                victimIdx
);
  logic             foundFree;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] oldIdx;
  logic [AGE_W-1:0] oldAge;

  always_comb begin
    foundFree = 1'b0;
    freeIdx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!validVec[i] && !foundFree) begin
        foundFree = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
    oldAge = ageVec[0];
    oldIdx = '0;
    for (int i = 1; i < ENTRIES; i++) begin
      if (ageVec[i] > oldAge) begin   // strict: lowest index keeps ties
        oldAge = ageVec[i];
        oldIdx = IDX_W'(i);
      end
    end
    victimIdx = foundFree ? freeIdx : oldIdx;
  end

  // R4: an empty entry is always chosen while one exists
  p_invalid_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~validVec)) |-> !validVec[victimIdx]);

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_oldest
      // R7: the victim in a full directory is never younger than any entry
      p_victim_oldest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&validVec) |-> (ageVec[victimIdx] >= ageVec[g]));
    end
  endgenerate
endmodule

// File: rtl/assoc_dir_datapath.sv
module assoc_dir_datapath
  import assoc_dir_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 14,
  parameter int AGE_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dirStrobe_t        strobe,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              anyMatch,
  output logic [IDX_W-1:0]  matchIdx,
  output logic [IDX_W-1:0]  victimIdx
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [ENTRIES-1:0]             validQ;
  logic [ENTRIES-1:0][TAG_W-1:0]  tagQ;
  logic [ENTRIES-1:0][AGE_W-1:0]  ageQ;
  logic [ENTRIES-1:0]             matchVec;
  logic [ENTRIES-1:0]             fillSel;
  logic [ENTRIES-1:0]             wipe;

  assoc_dir_victim #(.ENTRIES(ENTRIES), .AGE_W(AGE_W)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .validVec  (validQ),
    .ageVec    (ageQ),
    .victimIdx (victimIdx)
  );

  always_comb begin
    matchIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) matchIdx = matchIdx | IDX_W'(i);
    end
  end

  assign anyMatch = |matchVec;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      assign matchVec[g] = validQ[g] && (tagQ[g] == reqTag);
      assign fillSel[g]  = strobe.install && (victimIdx == IDX_W'(g));
      assign wipe[g]     = fillSel[g] || (strobe.clearHit && matchVec[g]);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          validQ[g] <= 1'b0;
          tagQ[g]   <= '0;
          ageQ[g]   <= '0;
        end else begin
          if (fillSel[g]) begin
            validQ[g] <= 1'b1;
            tagQ[g]   <= reqTag;
          end
          if (wipe[g])                ageQ[g] <= '0;
          else if (ageQ[g] != AGE_MAX) ageQ[g] <= ageQ[g] + 1'b1;
        end
      end

      // R5: an entry not cleared never shows age zero on the next cycle
      p_age_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wipe[g] |=> (ageQ[g] != '0));
    end
  endgenerate

  // R3: an install leaves the victim valid and holding the request tag
  p_install_writes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.install |=> (validQ[$past(victimIdx)] && tagQ[$past(victimIdx)] == $past(reqTag)));

  // R6: a lookup hit leaves the matching entry with zero age
  p_clear_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.clearHit && anyMatch) |=> (ageQ[$past(matchIdx)] == '0));

  // R8: no two valid entries ever hold the same tag
  p_one_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(matchVec));
endmodule

// File: rtl/assoc_dir_ctrl.sv
module assoc_dir_ctrl
  import assoc_dir_pkg::*;
(
  input  logic       lookupValid,
  input  logic       allocValid,
  input  logic       anyMatch,
  output dirStrobe_t strobe,
  output logic       hit
);
  always_comb begin
    strobe.clearHit = lookupValid && anyMatch;
    strobe.install  = allocValid && !anyMatch;   // duplicate allocate dropped
    hit             = lookupValid && anyMatch;
  end
endmodule

// File: rtl/assoc_tag_dir.sv
module assoc_tag_dir
  import assoc_dir_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 14,
  parameter int AGE_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookupValid,
  input  logic              allocValid,
  input  logic [TAG_W-1:0]  lookupTag,
  output logic              hit,
  output logic [IDX_W-1:0]  hitIndex,
  output logic [IDX_W-1:0]  victimIndex
);
  dirStrobe_t       strobe;
  logic             anyMatch;
  logic [IDX_W-1:0] matchIdx;

  assoc_dir_ctrl u_ctrl (
    .lookupValid (lookupValid),
    .allocValid  (allocValid),
    .anyMatch    (anyMatch),
    .strobe      (strobe),
    .hit         (hit)
  );

  assoc_dir_datapath #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .AGE_W(AGE_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .reqTag    (lookupTag),
    .anyMatch  (anyMatch),
    .matchIdx  (matchIdx),
    .victimIdx (victimIndex)
  );

  assign hitIndex = hit ? matchIdx : '0;
endmodule

// File: tb/assoc_tag_dir_tb.sv
module assoc_tag_dir_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lookupValid = 1'b0;
  logic       allocValid = 1'b0;
  logic [13:0] lookupTag = '0;
  logic       hit;
  logic [5:0] hitIndex;
  logic [5:0] victimIndex;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assoc_tag_dir u_dut (
    .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid), .allocValid(allocValid),
    .lookupTag(lookupTag), .hit(hit), .hitIndex(hitIndex), .victimIndex(victimIndex)
  );

  function automatic logic [13:0] tagOf(int i);
    return 14'h1000 + 14'(i);
  endfunction

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    lookupValid = 1'b1; lookupTag = tagOf(0);
    #1;
    chk("R1 hit after reset", int'(hit), 0);
    chk("R1 victim after reset", int'(victimIndex), 0);
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  task automatic t_fill();
    for (int i = 0; i < 64; i++) begin
      allocValid = 1'b1; lookupTag = tagOf(i);
      #1;
      chk("R4 lowest empty entry", int'(victimIndex), i);
      @(negedge clk);
    end
    allocValid = 1'b0;
  endtask

  task automatic t_lookup_all();
    for (int i = 0; i < 64; i++) begin
      lookupValid = 1'b1; lookupTag = tagOf(i);
      #1;
      chk("R2 hit on stored tag", int'(hit), 1);
      chk("R3 installed index", int'(hitIndex), i);
      @(negedge clk);
    end
    lookupValid = 1'b0;
    #1;
    chk("R7 oldest entry is victim", int'(victimIndex), 0);
    lookupValid = 1'b1; lookupTag = tagOf(0);
    @(negedge clk);
    lookupValid = 1'b0;
    #1;
    chk("R6 hit clears age", int'(victimIndex), 1);
  endtask

  task automatic t_saturate();
    repeat (300) @(negedge clk);
    #1;
    chk("R5 R7 saturated tie picks lowest", int'(victimIndex), 0);
    for (int i = 0; i < 63; i++) begin
      lookupValid = 1'b1; lookupTag = tagOf(i);
      @(negedge clk);
    end
    lookupValid = 1'b0;
    #1;
    chk("R5 saturated entry beats younger", int'(victimIndex), 63);
    lookupValid = 1'b1; lookupTag = tagOf(63);
    @(negedge clk);
    lookupValid = 1'b0;
    #1;
    chk("R6 victim moves after access", int'(victimIndex), 0);
  endtask

  task automatic t_miss();
    lookupValid = 1'b1; lookupTag = 14'h0055;
    #1;
    chk("R2 miss on absent tag", int'(hit), 0);
    chk("R2 index zero on miss", int'(hitIndex), 0);
    lookupValid = 1'b0; lookupTag = tagOf(10);
    #1;
    chk("R9 no hit without strobe", int'(hit), 0);
    @(negedge clk);
  endtask

  task automatic t_dup_and_replace();
    allocValid = 1'b1; lookupTag = tagOf(5);
    #1;
    chk("R8 victim before duplicate", int'(victimIndex), 0);
    @(negedge clk);
    allocValid = 1'b0;
    #1;
    chk("R8 duplicate leaves victim alone", int'(victimIndex), 0);
    lookupValid = 1'b1; lookupTag = tagOf(5);
    #1;
    chk("R8 tag still at its entry", int'(hitIndex), 5);
    @(negedge clk);
    lookupValid = 1'b0;
    allocValid = 1'b1; lookupTag = 14'h2222;
    #1;
    chk("R3 victim for replacement", int'(victimIndex), 0);
    @(negedge clk);
    allocValid = 1'b0;
    lookupValid = 1'b1; lookupTag = 14'h2222;
    #1;
    chk("R3 new tag hits", int'(hit), 1);
    chk("R3 new tag index", int'(hitIndex), 0);
    @(negedge clk);
    lookupTag = tagOf(0);
    #1;
    chk("R3 evicted tag misses", int'(hit), 0);
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_lookup_all();
    t_saturate();
    t_miss();
    t_dup_and_replace();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule